// File: doc/BRIEF.md
# Shared Configuration Register File

This block is a small bank of configuration registers that hangs on a shared interconnect as one slave. Any bus master can reach it. A request is claimed only when the top byte of the address matches the register window. Each entry keeps sixteen data bits. Writes and reads are single-beat, and each one is closed by a one-cycle acknowledge.

Entry zero has a second role. Its contents drive a parallel output at all times, and the upstream arbiter reads that output as its packed table of 2-bit priority fields. A master writes entry zero and the new priorities take effect without any further handshake.

The control path is a two-state machine. In `ST_IDLE` the block waits for a request. The transition *accept* (cycle, strobe and a window hit all high) performs the write, captures the read data and moves to `ST_ACK`. In `ST_ACK` the acknowledge is driven high. The transition *release* returns to `ST_IDLE` on the next edge, whatever the bus inputs are.

Top module: `cfgreg_slave`

## Requirements
- R1: Reset clears all 16 entries to zero and holds `ack_o` low, `rdata_o` at zero and `prio_o` at zero.
- R2: A request is claimed only when `addr_i[31:24]` equals 0xFF. Any other address gets no acknowledge and changes no entry.
- R3: After an accepted request, `ack_o` is high for exactly one cycle, in the cycle after the accepting edge. It is low again in the following cycle even if the strobe stays high.
- R4: The entry index is `addr_i[5:2]`, so entry n sits at 0xFF00_0000 + 4·n. Bits [23:6] and [1:0] do not affect which entry is selected. A value written through any address that aliases to an entry reads back from that entry.
- R5: Only bits [15:0] of the write data are stored. Read data bits [31:16] are always zero.
- R6: `sel_i[0]` enables the write of entry bits [7:0] and `sel_i[1]` enables bits [15:8]. `sel_i[3:2]` have no effect.
- R7: `prio_o` always equals entry 0. It changes only on the edge that accepts a write to entry 0.
- R8: A strobe while `cyc_i` is low is ignored: there is no acknowledge and no write.
- R9: `rdata_o` is zero whenever `ack_o` is low. During the acknowledge cycle it carries the entry contents as they were before the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 32 | Byte address |
| sel_i | input | 4 | Byte-lane enables |
| wdata_i | input | 32 | Write data |
| ack_o | output | 1 | One-cycle acknowledge |
| rdata_o | output | 32 | Read data, valid while `ack_o` is high |
| prio_o | output | 16 | Continuous copy of entry 0 (arbiter priority fields) |

## Verification
The bench builds the block with its default parameters: a 32-bit bus, a 0xFF window byte, sixteen entries and sixteen kept bits. With sixteen entries, a sweep of every index fits in a few hundred cycles. With sixteen kept bits, both enabled byte lanes and both disabled upper lanes can be exercised. Aliased addresses, near-miss window bytes, a strobe held through the acknowledge and a reset in the middle of a run are all reachable with these values.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_ACK  = 1'b1
    } cfg_state_e;
endpackage

// File: rtl/cfgreg_decode.sv
module cfgreg_decode #(
    parameter int WIN_W = 8,
    parameter logic [WIN_W-1:0] WINDOW = 8'hFF,
    parameter int IDX_W = 4
) (
    input  logic [WIN_W-1:0] win_bits,
    input  logic [IDX_W-1:0] idx_bits,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        hit = (win_bits == WINDOW);
        idx = idx_bits;
    end
endmodule

// File: rtl/cfgreg_bank.sv
module cfgreg_bank #(
    parameter int NUM_REGS = 16,
    parameter int KEEP_W   = 16,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int LANES   = KEEP_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LANES-1:0]  lane_en,
    input  logic [KEEP_W-1:0] wr_data,
    output logic [KEEP_W-1:0] rd_data,
    output logic [KEEP_W-1:0] entry0
);
    logic [KEEP_W-1:0] mem [NUM_REGS];

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            always_ff @(posedge clk or posedge rst) begin
                if (rst)
                    mem[r][l*8 +: 8] <= '0;
                else if (wr_en && lane_en[l] && (idx == IDX_W'(r)))
                    mem[r][l*8 +: 8] <= wr_data[l*8 +: 8];
            end
        end
    end

    always_comb begin
        rd_data = mem[idx];
        entry0  = mem[0];
    end
endmodule

// File: rtl/cfgreg_slave.sv
module cfgreg_slave #(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 16,
    parameter int KEEP_W   = 16,
    parameter int WIN_W    = 8,
    parameter logic [WIN_W-1:0] WINDOW = 8'hFF,
    localparam int SEL_W   = DATA_W / 8,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int LANES   = KEEP_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_i,
    input  logic              stb_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              ack_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [KEEP_W-1:0] prio_o
);
    import cfgreg_pkg::*;

    cfg_state_e        state_q, state_d;
    logic              hit;
    logic [IDX_W-1:0]  idx;
    logic              accept;
    logic [KEEP_W-1:0] bank_rd;
    logic [KEEP_W-1:0] rdata_q;

    logic unused_bits;
    assign unused_bits = ^{addr_i[ADDR_W-WIN_W-1:IDX_W+2], addr_i[1:0],
                           sel_i[SEL_W-1:LANES], wdata_i[DATA_W-1:KEEP_W]};

    cfgreg_decode #(.WIN_W(WIN_W), .WINDOW(WINDOW), .IDX_W(IDX_W)) u_decode (
        .win_bits (addr_i[ADDR_W-1 -: WIN_W]),
        .idx_bits (addr_i[IDX_W+1:2]),
        .hit      (hit),
        .idx      (idx)
    );

    assign accept = (state_q == ST_IDLE) && cyc_i && stb_i && hit;

    cfgreg_bank #(.NUM_REGS(NUM_REGS), .KEEP_W(KEEP_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (accept && we_i),
        .idx     (idx),
        .lane_en (sel_i[LANES-1:0]),
        .wr_data (wdata_i[KEEP_W-1:0]),
        .rd_data (bank_rd),
        .entry0  (prio_o)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_ACK;
            ST_ACK:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) rdata_q <= bank_rd;
        end
    end

    always_comb begin
        ack_o   = 1'b0;
        rdata_o = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ACK: begin
                ack_o   = 1'b1;
                rdata_o = DATA_W'(rdata_q);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cfgreg_checker.sv
module cfgreg_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int KEEP_W = 16,
    parameter int WIN_W  = 8,
    parameter logic [WIN_W-1:0] WINDOW = 8'hFF,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cyc_i,
    input logic              stb_i,
    input logic              we_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              ack_o,
    input logic [DATA_W-1:0] rdata_o,
    input logic [KEEP_W-1:0] prio_o
);
    logic unused_chk;
    assign unused_chk = ^{addr_i[ADDR_W-WIN_W-1:IDX_W+2], addr_i[1:0]};

    logic in_win;
    logic wr_e0;
    assign in_win = (addr_i[ADDR_W-1 -: WIN_W] == WINDOW);
    assign wr_e0  = cyc_i && stb_i && we_i && in_win && !ack_o &&
                    (addr_i[IDX_W+1:2] == '0);

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> !ack_o);                                             // R3
    AST_ACK_HAS_HIT: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> $past(stb_i && in_win));                             // R2
    AST_ACK_NEEDS_CYC: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> $past(cyc_i));                                       // R8
    AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        rdata_o[DATA_W-1:KEEP_W] == '0);                               // R5
    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !ack_o |-> (rdata_o == '0));                                   // R9
    AST_PRIO_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_e0) |-> $stable(prio_o));                            // R7
endmodule

bind cfgreg_slave cfgreg_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEEP_W(KEEP_W),
    .WIN_W(WIN_W), .WINDOW(WINDOW), .IDX_W(IDX_W)
) i_chk (
    .clk(clk), .rst(rst), .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i),
    .addr_i(addr_i), .ack_o(ack_o), .rdata_o(rdata_o), .prio_o(prio_o)
);

// File: tb/test_cfgreg_slave.sv
module test_cfgreg_slave;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc_i = 1'b0, stb_i = 1'b0, we_i = 1'b0;
    logic [31:0] addr_i = '0;
    logic [3:0]  sel_i = '0;
    logic [31:0] wdata_i = '0;
    logic        ack_o;
    logic [31:0] rdata_o;
    logic [15:0] prio_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cfgreg_slave i_cfgreg_slave (
        .clk(clk), .rst(rst), .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i),
        .addr_i(addr_i), .sel_i(sel_i), .wdata_i(wdata_i),
        .ack_o(ack_o), .rdata_o(rdata_o), .prio_o(prio_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, stepped on every rising edge
    logic [15:0] m_regs [16];
    logic        m_ack = 1'b0;
    logic [15:0] m_rd  = '0;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) m_regs[i] = '0;
            m_ack = 1'b0;
            m_rd  = '0;
        end else if (m_ack) begin
            m_ack = 1'b0;
        end else if (cyc_i && stb_i && addr_i[31:24] == 8'hFF) begin
            int k;
            k = int'(addr_i[5:2]);
            m_rd = m_regs[k];
            if (we_i) begin
                if (sel_i[0]) m_regs[k][7:0]  = wdata_i[7:0];
                if (sel_i[1]) m_regs[k][15:8] = wdata_i[15:8];
            end
            m_ack = 1'b1;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            check("R3 ack", {31'b0, ack_o}, {31'b0, m_ack});
            check("R9 rdata", rdata_o, m_ack ? {16'h0, m_rd} : 32'h0);
            check("R7 prio", {16'h0, prio_o}, {16'h0, m_regs[0]});
        end
    end

    task automatic access(input logic we, input logic [31:0] a, input logic [3:0] s,
                          input logic [31:0] d, output logic [31:0] rd, output bit got);
        @(posedge clk); #2;
        cyc_i = 1'b1; stb_i = 1'b1; we_i = we; addr_i = a; sel_i = s; wdata_i = d;
        got = 0; rd = '0;
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            if (ack_o) begin got = 1; rd = rdata_o; break; end
        end
        @(posedge clk); #2;
        cyc_i = 1'b0; stb_i = 1'b0; we_i = 1'b0;
    endtask

    task automatic rd_entry(input logic [31:0] a, output logic [31:0] v);
        bit g;
        access(1'b0, a, 4'hF, 32'h0, v, g);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: got hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        bit g;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        check("R1 ack after reset", {31'b0, ack_o}, 32'h0);
        check("R1 rdata after reset", rdata_o, 32'h0);
        check("R1 prio after reset", {16'h0, prio_o}, 32'h0);
        for (int i = 0; i < 16; i++) begin
            rd_entry(32'hFF00_0000 + (i << 2), v);
            check("R1 entry zero", v, 32'h0);
        end

        access(1'b1, 32'hFF00_000C, 4'hF, 32'hBEEF_1234, v, g);
        check("R3 write acked", {31'b0, g}, 32'h1);
        rd_entry(32'hFF00_000C, v);
        check("R5 upper dropped", v, 32'h0000_1234);
        rd_entry(32'hFF12_344F, v);
        check("R4 alias read", v, 32'h0000_1234);

        access(1'b1, 32'hFF00_000C, 4'b0001, 32'h0000_00AB, v, g);
        check("R9 write returns old", v, 32'h0000_1234);
        rd_entry(32'hFF00_000C, v);
        check("R6 low lane", v, 32'h0000_12AB);
        access(1'b1, 32'hFF00_000C, 4'b0010, 32'h0000_CD00, v, g);
        rd_entry(32'hFF00_000C, v);
        check("R6 high lane", v, 32'h0000_CDAB);
        access(1'b1, 32'hFF00_000C, 4'b1100, 32'hFFFF_FFFF, v, g);
        rd_entry(32'hFF00_000C, v);
        check("R6 upper lanes inert", v, 32'h0000_CDAB);

        access(1'b1, 32'hFE00_000C, 4'hF, 32'h0000_5555, v, g);
        check("R2 miss no ack", {31'b0, g}, 32'h0);
        access(1'b1, 32'h7F00_000C, 4'hF, 32'h0000_5555, v, g);
        check("R2 miss no ack high bit", {31'b0, g}, 32'h0);
        rd_entry(32'hFF00_000C, v);
        check("R2 miss no write", v, 32'h0000_CDAB);

        @(posedge clk); #2;
        stb_i = 1'b1; we_i = 1'b1; addr_i = 32'hFF00_000C; sel_i = 4'hF; wdata_i = 32'h1111;
        g = 0;
        repeat (3) begin @(negedge clk); if (ack_o) g = 1; end
        @(posedge clk); #2; stb_i = 1'b0; we_i = 1'b0;
        check("R8 no ack without cyc", {31'b0, g}, 32'h0);
        rd_entry(32'hFF00_000C, v);
        check("R8 no write without cyc", v, 32'h0000_CDAB);

        access(1'b1, 32'hFF00_0000, 4'hF, 32'h0000_E4A1, v, g);
        @(negedge clk);
        check("R7 prio follows entry 0", {16'h0, prio_o}, 32'h0000_E4A1);

        for (int i = 0; i < 16; i++)
            access(1'b1, 32'hFF00_0000 + (i << 2), 4'hF, (i * 32'h1111) ^ 32'h0F0F, v, g);
        for (int i = 0; i < 16; i++) begin
            rd_entry(32'hFF00_0000 + (i << 2), v);
            check("R4 sweep readback", v, ((i * 32'h1111) ^ 32'h0F0F) & 32'hFFFF);
        end

        // strobe held through acknowledge: one ack, one gap, one ack
        @(posedge clk); #2;
        cyc_i = 1'b1; stb_i = 1'b1; we_i = 1'b0; addr_i = 32'hFF00_0008;
        repeat (4) @(posedge clk);
        #2 cyc_i = 1'b0; stb_i = 1'b0;
        @(negedge clk);
        check("R9 idle rdata", rdata_o, 32'h0);

        @(posedge clk); #2 rst = 1'b1;
        @(posedge clk); #2 rst = 1'b0;
        @(negedge clk);
        check("R1 prio after mid reset", {16'h0, prio_o}, 32'h0);
        rd_entry(32'hFF00_0004, v);
        check("R1 entry cleared", v, 32'h0);

        repeat (3) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule